// File: doc/BRIEF.md
# In-Memory Bitwise AND/OR Command Sequencer

This controller turns a single request, "combine row A with row B by AND or by OR and write the outcome into row C", into a fixed stream of row commands for one memory subarray. The block never moves any data itself. It relies on two facts about the array. Activating a source row and then a destination row copies a full row. Activating three rows at once leaves their bitwise majority in all three.

Three scratch rows are used, called scratch-1, scratch-2 and scratch-3. A and B are first copied into scratch-1 and scratch-2. A constant row is then copied into scratch-3: the all-zero row makes the majority equal to A AND B, and the all-ones row makes it equal to A OR B. The three scratch rows are activated together and then precharged. Finally, scratch-1 is copied into C.

Commands leave through a valid/ready port and can be held back for any number of cycles. A request is checked when it is offered. A request that would copy across subarrays, or that would overwrite a constant row, is refused with a one-cycle error pulse and produces no commands.

Top module: `bitop_seq`

## Requirements
- R1: While reset is asserted and at the first cycle after it, busy, done, err and cmd_valid are 0, req_ready is 1 and cmd_kind is 0 (none).
- R2: An accepted valid request (req_valid high while req_ready is high) raises busy and cmd_valid in the next cycle. The block then emits exactly 14 commands in this order, where the kind encoding is 1 = ACTIVATE, 2 = PRECHARGE, 3 = triple activation, and PRECHARGE carries row 0. The order is: ACT A, ACT S1, PRE, ACT B, ACT S2, PRE, ACT K, ACT S3, PRE, TRIPLE, PRE, ACT S1, ACT C, PRE.
- R3: The constant row K (command 7) is the all-zero row when req_op is 0 (AND) and the all-ones row when req_op is 1 (OR).
- R4: The triple activation carries the scratch-1 row address and is immediately followed by a PRECHARGE. The final copy uses scratch-1 as its source.
- R5: While cmd_valid is high and cmd_ready is low, the next cycle keeps cmd_valid high and keeps cmd_kind and cmd_row unchanged.
- R6: In the cycle after the 14th command is accepted, done is high for exactly one cycle, busy is low and req_ready is high.
- R7: The row index is split at bit SUB_W: the bits above it select the subarray, and the constant and scratch rows live in subarray RSV_SUB. A request is refused if A, B or C lies in another subarray, or if C equals the all-zero or all-ones row. A refused request gives err high for one cycle in the next cycle, leaves busy low and issues no command.
- R8: req_ready is low while busy. A req_valid offered during a sequence is ignored, and the stream continues with the original operands.
- R9: done and err are never high in the same cycle, and err is never high while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_op | input | 1 | 0 = AND, 1 = OR |
| req_a | input | ROW_W | First operand row |
| req_b | input | ROW_W | Second operand row |
| req_c | input | ROW_W | Result row |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle refusal pulse |
| cmd_valid | output | 1 | Command presented |
| cmd_ready | input | 1 | Subarray accepts the command |
| cmd_kind | output | 2 | 0 none, 1 ACTIVATE, 2 PRECHARGE, 3 triple activation |
| cmd_row | output | ROW_W | Row address of the command |

## Verification
Requests are tried with both operations, so the two streams differ only in the constant row of command 7. Operands are set equal to each other, to the all-zero constant row and to scratch-1, which shows that the stream depends only on the addresses and never on aliasing. Refusal cases move each of A, B and C alone into a foreign subarray and aim C at each constant row, so that every locality term is shown to matter on its own. Random cmd_ready gaps and a request offered mid-sequence show that stalls lose or repeat no command and that the latched operands hold.

// File: rtl/bitop_pkg.sv
`timescale 1ns/1ps
package bitop_pkg;

  typedef enum logic [1:0] {
    CK_NONE = 2'd0,
    CK_ACT  = 2'd1,
    CK_PRE  = 2'd2,
    CK_TRA  = 2'd3
  } cmd_kind_e;

  typedef enum logic [2:0] {
    SEL_NONE = 3'd0,
    SEL_A    = 3'd1,
    SEL_B    = 3'd2,
    SEL_C    = 3'd3,
    SEL_K    = 3'd4,
    SEL_S1   = 3'd5,
    SEL_S2   = 3'd6,
    SEL_S3   = 3'd7
  } row_sel_e;

  localparam int unsigned SEQ_LEN = 14;
  localparam int unsigned STEP_W  = $clog2(SEQ_LEN);

  // Kind of command at a given position of the fixed stream.
  function automatic cmd_kind_e step_kind(input logic [STEP_W-1:0] s);
    case (s)
      4'd2, 4'd5, 4'd8, 4'd10, 4'd13: step_kind = CK_PRE;
      4'd9:                           step_kind = CK_TRA;
      default:                        step_kind = CK_ACT;
    endcase
  endfunction

  // Which row the command at a given position addresses.
  function automatic row_sel_e step_sel(input logic [STEP_W-1:0] s);
    case (s)
      4'd0:  step_sel = SEL_A;
      4'd1:  step_sel = SEL_S1;
      4'd3:  step_sel = SEL_B;
      4'd4:  step_sel = SEL_S2;
      4'd6:  step_sel = SEL_K;
      4'd7:  step_sel = SEL_S3;
      4'd9:  step_sel = SEL_S1;
      4'd11: step_sel = SEL_S1;
      4'd12: step_sel = SEL_C;
      default: step_sel = SEL_NONE;
    endcase
  endfunction

endpackage

// File: rtl/bitop_req_check.sv
`timescale 1ns/1ps
module bitop_req_check #(
  parameter int unsigned ROW_W   = 12,
  parameter int unsigned SUB_W   = 9,
  parameter int unsigned RSV_SUB = 0,
  parameter logic [ROW_W-1:0] ZERO_ROW = '0,
  parameter logic [ROW_W-1:0] ONE_ROW  = '0
) (
  input  logic [ROW_W-1:0] row_a,
  input  logic [ROW_W-1:0] row_b,
  input  logic [ROW_W-1:0] row_c,
  output logic             ok
);
  localparam int unsigned IDX_W = ROW_W - SUB_W;
  localparam logic [IDX_W-1:0] HOME = IDX_W'(RSV_SUB);

  function automatic logic [IDX_W-1:0] sub_of(input logic [ROW_W-1:0] r);
    sub_of = r[ROW_W-1:SUB_W];
  endfunction

  logic same_sub;
  logic c_free;

  always_comb begin
    same_sub = (sub_of(row_a) == HOME) && (sub_of(row_b) == HOME) &&
               (sub_of(row_c) == HOME);
    c_free   = (row_c != ZERO_ROW) && (row_c != ONE_ROW);
    ok       = same_sub && c_free;
  end
endmodule

// File: rtl/bitop_step_dec.sv
`timescale 1ns/1ps
module bitop_step_dec
  import bitop_pkg::*;
#(
  parameter int unsigned ROW_W = 12,
  parameter logic [ROW_W-1:0] ZERO_ROW = '0,
  parameter logic [ROW_W-1:0] ONE_ROW  = '0,
  parameter logic [ROW_W-1:0] S1_ROW   = '0,
  parameter logic [ROW_W-1:0] S2_ROW   = '0,
  parameter logic [ROW_W-1:0] S3_ROW   = '0
) (
  input  logic [STEP_W-1:0] step,
  input  logic              op_or,
  input  logic [ROW_W-1:0]  row_a,
  input  logic [ROW_W-1:0]  row_b,
  input  logic [ROW_W-1:0]  row_c,
  output cmd_kind_e         kind,
  output logic [ROW_W-1:0]  row
);
  row_sel_e sel;

  always_comb begin
    kind = step_kind(step);
    sel  = step_sel(step);
    case (sel)
      SEL_A:   row = row_a;
      SEL_B:   row = row_b;
      SEL_C:   row = row_c;
      SEL_K:   row = op_or ? ONE_ROW : ZERO_ROW;
      SEL_S1:  row = S1_ROW;
      SEL_S2:  row = S2_ROW;
      SEL_S3:  row = S3_ROW;
      default: row = '0;
    endcase
  end
endmodule

// File: rtl/bitop_seq.sv
`timescale 1ns/1ps
module bitop_seq
  import bitop_pkg::*;
#(
  parameter int unsigned ROW_W   = 12,
  parameter int unsigned SUB_W   = 9,
  parameter int unsigned RSV_SUB = 0,
  parameter int unsigned ZERO_OFF = 0,
  parameter int unsigned ONE_OFF  = 1,
  parameter int unsigned S1_OFF   = 2,
  parameter int unsigned S2_OFF   = 3,
  parameter int unsigned S3_OFF   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_op,
  input  logic [ROW_W-1:0] req_a,
  input  logic [ROW_W-1:0] req_b,
  input  logic [ROW_W-1:0] req_c,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic             cmd_valid,
  input  logic             cmd_ready,
  output logic [1:0]       cmd_kind,
  output logic [ROW_W-1:0] cmd_row
);
  localparam int unsigned BASE = RSV_SUB << SUB_W;
  localparam logic [ROW_W-1:0] ZERO_ROW = ROW_W'(BASE + ZERO_OFF);
  localparam logic [ROW_W-1:0] ONE_ROW  = ROW_W'(BASE + ONE_OFF);
  localparam logic [ROW_W-1:0] S1_ROW   = ROW_W'(BASE + S1_OFF);
  localparam logic [ROW_W-1:0] S2_ROW   = ROW_W'(BASE + S2_OFF);
  localparam logic [ROW_W-1:0] S3_ROW   = ROW_W'(BASE + S3_OFF);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(SEQ_LEN - 1);

  logic              busy_q, done_q, err_q, op_q;
  logic [STEP_W-1:0] step_q;
  logic [ROW_W-1:0]  a_q, b_q, c_q;

  // Named internal events, also watched by the bound checker.
  logic              req_ok;
  logic              req_take;
  logic              req_bad;
  logic              cmd_fire;
  logic              last_fire;
  logic [ROW_W-1:0]  scratch1_row;
  cmd_kind_e         dec_kind;
  logic [ROW_W-1:0]  dec_row;

  bitop_req_check #(
    .ROW_W(ROW_W), .SUB_W(SUB_W), .RSV_SUB(RSV_SUB),
    .ZERO_ROW(ZERO_ROW), .ONE_ROW(ONE_ROW)
  ) u_check (
    .row_a(req_a), .row_b(req_b), .row_c(req_c), .ok(req_ok)
  );

  bitop_step_dec #(
    .ROW_W(ROW_W), .ZERO_ROW(ZERO_ROW), .ONE_ROW(ONE_ROW),
    .S1_ROW(S1_ROW), .S2_ROW(S2_ROW), .S3_ROW(S3_ROW)
  ) u_dec (
    .step(step_q), .op_or(op_q), .row_a(a_q), .row_b(b_q), .row_c(c_q),
    .kind(dec_kind), .row(dec_row)
  );

  assign scratch1_row = S1_ROW;
  assign req_take     = req_valid && !busy_q && req_ok;
  assign req_bad      = req_valid && !busy_q && !req_ok;
  assign cmd_fire     = busy_q && cmd_ready;
  assign last_fire    = cmd_fire && (step_q == LAST_STEP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      op_q   <= 1'b0;
      step_q <= '0;
      a_q    <= '0;
      b_q    <= '0;
      c_q    <= '0;
    end else begin
      done_q <= last_fire;
      err_q  <= req_bad;
      if (req_take) begin
        busy_q <= 1'b1;
        step_q <= '0;
        op_q   <= req_op;
        a_q    <= req_a;
        b_q    <= req_b;
        c_q    <= req_c;
      end else if (last_fire) begin
        busy_q <= 1'b0;
        step_q <= '0;
      end else if (cmd_fire) begin
        step_q <= step_q + 1'b1;
      end
    end
  end

  always_comb begin
    req_ready = !busy_q;
    busy      = busy_q;
    done      = done_q;
    err       = err_q;
    cmd_valid = busy_q;
    cmd_kind  = busy_q ? dec_kind : CK_NONE;
    cmd_row   = busy_q ? dec_row : '0;
  end
endmodule

// File: rtl/bitop_seq_chk.sv
`timescale 1ns/1ps
module bitop_seq_chk #(
  parameter int unsigned ROW_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             busy,
  input logic             done,
  input logic             err,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic [1:0]       cmd_kind,
  input logic [ROW_W-1:0] cmd_row,
  input logic             req_take,
  input logic             req_bad,
  input logic             cmd_fire,
  input logic             last_fire,
  input logic [ROW_W-1:0] scratch1_row
);
  assert_take_starts_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_take |=> busy && cmd_valid && cmd_kind == 2'd1);

  assert_tra_row_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_kind == 2'd3) |-> cmd_row == scratch1_row);

  assert_tra_then_pre_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_fire && cmd_kind == 2'd3) |=> cmd_valid && cmd_kind == 2'd2);

  assert_stall_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> cmd_valid && $stable(cmd_kind) && $stable(cmd_row));

  assert_done_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    last_fire |=> done && !busy && req_ready);

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_reject_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_bad |=> err && !busy && !cmd_valid);

  assert_busy_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);

  assert_flags_apart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !busy && !done);
endmodule

bind bitop_seq bitop_seq_chk #(.ROW_W(ROW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .busy(busy), .done(done),
  .err(err), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_kind(cmd_kind),
  .cmd_row(cmd_row), .req_take(req_take), .req_bad(req_bad),
  .cmd_fire(cmd_fire), .last_fire(last_fire), .scratch1_row(scratch1_row)
);

// File: tb/bitop_seq_test.sv
`timescale 1ns/1ps
module bitop_seq_test;
  localparam int RW = 12;
  localparam int SW = 9;
  localparam logic [RW-1:0] ZR = 12'd0;
  localparam logic [RW-1:0] OR_ = 12'd1;
  localparam logic [RW-1:0] S1 = 12'd2;
  localparam logic [RW-1:0] S2 = 12'd3;
  localparam logic [RW-1:0] S3 = 12'd4;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_op = 0, cmd_ready = 0;
  logic [RW-1:0] req_a = 0, req_b = 0, req_c = 0;
  logic req_ready, busy, done, err, cmd_valid;
  logic [1:0] cmd_kind;
  logic [RW-1:0] cmd_row;

  int n_chk = 0, n_bad = 0;
  int ek[14];
  int er[14];
  int fill;

  always #5 clk = ~clk;

  bitop_seq #(.ROW_W(RW), .SUB_W(SW), .RSV_SUB(0), .ZERO_OFF(0), .ONE_OFF(1),
              .S1_OFF(2), .S2_OFF(3), .S3_OFF(4)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_a(req_a), .req_b(req_b), .req_c(req_c),
    .busy(busy), .done(done), .err(err), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_kind(cmd_kind), .cmd_row(cmd_row));

  task automatic chk(input bit cond, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!cond) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit bench_ok(input logic [RW-1:0] a, b, c);
    return (a >> SW) == 0 && (b >> SW) == 0 && (c >> SW) == 0 &&
           c != ZR && c != OR_;
  endfunction

  task automatic push(input int k, input int r);
    ek[fill] = k; er[fill] = r; fill++;
  endtask

  task automatic add_copy(input int src, input int dst);
    push(1, src); push(1, dst); push(2, 0);
  endtask

  task automatic build(input bit op, input logic [RW-1:0] a, b, c);
    fill = 0;
    add_copy(a, S1);
    add_copy(b, S2);
    add_copy(op ? OR_ : ZR, S3);
    push(3, S1); push(2, 0);
    add_copy(S1, c);
  endtask

  task automatic do_req(input bit op, input logic [RW-1:0] a, b, c);
    bit ok;
    int idx, cyc;
    bit rdy, stalled;
    int pk, pr;
    string tag;
    ok = bench_ok(a, b, c);
    build(op, a, b, c);
    @(negedge clk);
    req_valid = 1; req_op = op; req_a = a; req_b = b; req_c = c;
    @(negedge clk);
    req_valid = 0;
    if (!ok) begin
      chk(err == 1, "R7", "err after refused request", err, 1);
      chk(busy == 0 && cmd_valid == 0, "R7", "no stream after refusal", cmd_valid, 0);
      @(negedge clk);
      chk(err == 0, "R7", "err lasts one cycle", err, 0);
      chk(cmd_valid == 0, "R7", "still no command", cmd_valid, 0);
      return;
    end
    chk(busy == 1 && cmd_valid == 1, "R2", "busy after accept", busy, 1);
    idx = 0; cyc = 0; stalled = 0; pk = 0; pr = 0;
    while (idx < 14) begin
      tag = (idx == 6) ? "R3" : ((idx == 9 || idx == 11) ? "R4" : "R2");
      chk(cmd_valid == 1 && int'(cmd_kind) == ek[idx], tag, "command kind",
          int'(cmd_kind), ek[idx]);
      chk(int'(cmd_row) == er[idx], tag, "command row", int'(cmd_row), er[idx]);
      if (stalled)
        chk(int'(cmd_kind) == pk && int'(cmd_row) == pr, "R5", "held during stall",
            int'(cmd_row), pr);
      chk(req_ready == 0, "R8", "req_ready low while busy", req_ready, 0);
      pk = int'(cmd_kind); pr = int'(cmd_row);
      rdy = ($urandom % 3) != 0;
      cmd_ready = rdy;
      if (idx == 4) begin
        req_valid = 1; req_op = ~op; req_a = 12'd77; req_b = 12'd78; req_c = 12'd79;
      end
      @(negedge clk);
      req_valid = 0;
      if (rdy) idx++;
      stalled = !rdy;
      cyc++;
      if (cyc > 300) begin
        chk(0, "R2", "sequence hung", idx, 14);
        break;
      end
    end
    cmd_ready = 0;
    chk(done == 1, "R6", "done after last command", done, 1);
    chk(busy == 0 && req_ready == 1, "R6", "idle with done", busy, 0);
    chk(err == 0, "R9", "no err with done", err, 0);
    @(negedge clk);
    chk(done == 0, "R6", "done lasts one cycle", done, 0);
  endtask

  initial begin
    #1_500_000;
    chk(0, "R2", "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4471));
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && err == 0, "R1", "flags in reset", busy, 0);
    chk(cmd_valid == 0 && cmd_kind == 0 && req_ready == 1, "R1", "port idle in reset",
        cmd_valid, 0);
    rst_n = 1;
    @(negedge clk);
    chk(busy == 0 && cmd_valid == 0 && req_ready == 1, "R1", "idle after reset",
        busy, 0);

    do_req(0, 12'd100, 12'd200, 12'd300);
    do_req(1, 12'd100, 12'd200, 12'd300);
    do_req(1, 12'd55, 12'd55, 12'd56);
    do_req(0, ZR, OR_, 12'd511);
    do_req(1, 12'd9, 12'd10, S1);
    do_req(0, 12'd5, 12'd6, ZR);
    do_req(1, 12'd5, 12'd6, OR_);
    do_req(0, 12'd600, 12'd6, 12'd7);
    do_req(1, 12'd5, 12'd3900, 12'd7);
    do_req(0, 12'd5, 12'd6, 12'd1600);

    for (int i = 0; i < 40; i++) begin
      logic [RW-1:0] a, b, c;
      bit op;
      op = $urandom % 2;
      a = RW'($urandom % 512);
      b = RW'($urandom % 512);
      c = RW'(2 + $urandom % 510);
      if ($urandom % 4 == 0) begin
        case ($urandom % 3)
          0: a[RW-1:SW] = 3'(1 + $urandom % 7);
          1: b[RW-1:SW] = 3'(1 + $urandom % 7);
          default: c[RW-1:SW] = 3'(1 + $urandom % 7);
        endcase
      end
      do_req(op, a, b, c);
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule